// File: doc/BRIEF.md
# Peripheral Control-Line Interrupt Unit

This block holds the control-line logic of one channel of a parallel I/O port. It watches two synchronized peripheral control lines, C1 and C2. Each line has its own programmable active edge. An active edge on C1 sets the high flag, and an active edge on C2 sets the low flag. A flag latches whether or not its interrupt is enabled. The active-low request `irq_n` is asserted whenever a flag is set and its enable bit is on. Both flags are cleared by a read of the channel's control register.

C2 can also be turned around into an output. It can then drive a fixed level taken from the control word. It can act as a handshake line: it drops on a read of the port data and recovers on the next active C1 edge. It can also produce a one-clock low strobe after each port-data read.

The surrounding register file supplies the six-bit control word, the control-read and data-read pulses, and the synchronized pin levels. It reads back the two flags.

Top module: `ctl_line_irq`

## Requirements
- R1: When `rst` is sampled high, the next state is: both flags 0, `irq_n` 1, `c2_out` 1 and `c2_oe` 0.
- R2: Control bit 1 selects the active edge of C1 (0 falling, 1 rising). An active edge sets `flag_c1` in the cycle after the pin sample changes. An edge of the other polarity leaves the flag unchanged.
- R3: While control bit 5 is 0, C2 is an input and control bit 4 selects its active edge (0 falling, 1 rising). An active edge sets `flag_c2` one cycle later. While bit 5 is 1, edges on `c2_in` do not change `flag_c2`.
- R4: `irq_n` is 0 exactly when (`flag_c1` and control bit 0) or (`flag_c2` and control bit 3 and not control bit 5). A flag still sets while its enable is 0.
- R5: A `ctrl_rd` pulse clears both flags on the next cycle. A flag whose active edge occurs in the same cycle as the read stays set. Flags fall only after a control read.
- R6: With control bits 5 and 4 both 1, `c2_out` equals control bit 3 one cycle later.
- R7: With control bits 5,4,3 = 1,0,0 (handshake), a `data_rd` pulse drives `c2_out` low from the next cycle. It stays low until an active C1 edge, after which it is high from the next cycle. A read in the same cycle as that edge keeps it low.
- R8: With control bits 5,4,3 = 1,0,1 (strobe), `c2_out` is low for exactly the one cycle after each `data_rd` pulse and high otherwise.
- R9: `c2_oe` equals control bit 5 delayed by one cycle. `c2_out` is held high while C2 is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 6 | Control word; bit 2 is not used by this block |
| ctrl_rd | input | 1 | One-cycle pulse: control register read |
| data_rd | input | 1 | One-cycle pulse: port data read |
| c1_in | input | 1 | Synchronized C1 level |
| c2_in | input | 1 | Synchronized C2 level |
| flag_c1 | output | 1 | Interrupt flag from C1 (control read-back bit 7) |
| flag_c2 | output | 1 | Interrupt flag from C2 (control read-back bit 6) |
| irq_n | output | 1 | Active-low interrupt request |
| c2_out | output | 1 | C2 output level |
| c2_oe | output | 1 | C2 output enable |

## Verification
The assertions check several relations on every cycle:
- an enabled flag always pulls `irq_n` low, and a low `irq_n` always has a flag behind it;
- flags fall only after a control read;
- the output enable tracks bit 5 with a one-cycle lag;
- the level and strobe modes produce the right C2 value.

Edge polarity selection, the handshake recovery on a C1 edge, the set-beats-clear race, and C2 edges being ignored in output mode are shown only by the bench scenarios. There, a behavioural model is compared against every output on every clock.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int CTRL_W    = 6;
  localparam int NUM_LINES = 2;
  localparam int B_C1_EN   = 0;
  localparam int B_C1_RISE = 1;
  localparam int B_C2_EN   = 3;
  localparam int B_C2_SEL  = 4;
  localparam int B_C2_OUT  = 5;

  typedef enum logic [1:0] {
    C2_INPUT     = 2'd0,
    C2_HANDSHAKE = 2'd1,
    C2_STROBE    = 2'd2,
    C2_LEVEL     = 2'd3
  } c2_mode_e;

  function automatic c2_mode_e decode_c2(input logic [CTRL_W-1:0] c);
    if (!c[B_C2_OUT])      return C2_INPUT;
    else if (c[B_C2_SEL])  return C2_LEVEL;
    else if (c[B_C2_EN])   return C2_STROBE;
    else                   return C2_HANDSHAKE;
  endfunction
endpackage

// File: rtl/ctl_edge_flag.sv
module ctl_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_sel_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic hit_o,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;

  always_comb begin
    if (rise_sel_i) hit_o = arm_i & pin_i & ~prev_q;
    else            hit_o = arm_i & ~pin_i & prev_q;
  end

  always_ff @(posedge clk) begin
    prev_q <= pin_i;
    if (rst) flag_q <= 1'b0;
    else     flag_q <= hit_o | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ctl_c2_drive.sv
module ctl_c2_drive
  import ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  c2_mode_e mode_i,
  input  logic     level_i,
  input  logic     data_rd_i,
  input  logic     c1_hit_i,
  output logic     c2_o,
  output logic     oe_o
);
  logic c2_q;
  logic oe_q;
  logic c2_d;

  always_comb begin
    unique case (mode_i)
      C2_INPUT:     c2_d = 1'b1;
      C2_LEVEL:     c2_d = level_i;
      C2_STROBE:    c2_d = ~data_rd_i;
      C2_HANDSHAKE: c2_d = data_rd_i ? 1'b0 : (c1_hit_i ? 1'b1 : c2_q);
      default:      c2_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_q <= 1'b1;
      oe_q <= 1'b0;
    end else begin
      c2_q <= c2_d;
      oe_q <= (mode_i != C2_INPUT);
    end
  end

  assign c2_o = c2_q;
  assign oe_o = oe_q;
endmodule

// File: rtl/ctl_line_irq.sv
module ctl_line_irq
  import ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              ctrl_rd,
  input  logic              data_rd,
  input  logic              c1_in,
  input  logic              c2_in,
  output logic              flag_c1,
  output logic              flag_c2,
  output logic              irq_n,
  output logic              c2_out,
  output logic              c2_oe
);
  c2_mode_e mode;
  logic [NUM_LINES-1:0] pins, rise_sel, arm, hits, flags, enables;
  logic unused_sel;

  assign unused_sel = ctrl_i[2];
  assign mode       = decode_c2(ctrl_i);

  assign pins     = {c2_in, c1_in};
  assign rise_sel = {ctrl_i[B_C2_SEL], ctrl_i[B_C1_RISE]};
  assign arm      = {(mode == C2_INPUT), 1'b1};
  assign enables  = {ctrl_i[B_C2_EN] & (mode == C2_INPUT), ctrl_i[B_C1_EN]};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    ctl_edge_flag u_flag (
      .clk        (clk),
      .rst        (rst),
      .pin_i      (pins[g]),
      .rise_sel_i (rise_sel[g]),
      .arm_i      (arm[g]),
      .clr_i      (ctrl_rd),
      .hit_o      (hits[g]),
      .flag_o     (flags[g])
    );
  end

  ctl_c2_drive u_c2 (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode),
    .level_i   (ctrl_i[B_C2_EN]),
    .data_rd_i (data_rd),
    .c1_hit_i  (hits[0]),
    .c2_o      (c2_out),
    .oe_o      (c2_oe)
  );

  assign flag_c1 = flags[0];
  assign flag_c2 = flags[1];
  assign irq_n   = ~|(flags & enables);
endmodule

// File: rtl/ctl_line_irq_chk.sv
module ctl_line_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] ctrl_i,
  input logic       ctrl_rd,
  input logic       data_rd,
  input logic       c1_in,
  input logic       c2_in,
  input logic       flag_c1,
  input logic       flag_c2,
  input logic       irq_n,
  input logic       c2_out,
  input logic       c2_oe
);
  logic live_q;
  always_ff @(posedge clk) live_q <= ~rst;

  // R1
  p_reset_r1: assert property (@(posedge clk) rst |=> (!flag_c1 && !flag_c2 && c2_out && !c2_oe));

  // R4
  p_en_irq_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_c1 && ctrl_i[0]) |-> !irq_n);

  // R4
  p_irq_src_r4: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (flag_c1 || flag_c2));

  // R5
  p_fall_rd_r5: assert property (@(posedge clk) disable iff (rst)
    live_q && $fell(flag_c1) |-> $past(ctrl_rd));

  // R5
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (live_q && ctrl_rd && $stable(c1_in)) |=> !flag_c1);

  // R6
  p_level_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i[5:4] == 2'b11) |=> (c2_out == $past(ctrl_i[3])));

  // R8
  p_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i[5:3] == 3'b101 && data_rd) |=> !c2_out);

  // R9
  p_oe_r9: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (c2_oe == $past(ctrl_i[5])));
endmodule

bind ctl_line_irq ctl_line_irq_chk chk_i (
  .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
  .c1_in(c1_in), .c2_in(c2_in), .flag_c1(flag_c1), .flag_c2(flag_c2),
  .irq_n(irq_n), .c2_out(c2_out), .c2_oe(c2_oe)
);

// File: tb/ctl_line_irq_tb_top.sv
module ctl_line_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] ctrl_i;
  logic       ctrl_rd, data_rd, c1_in, c2_in;
  logic       flag_c1, flag_c2, irq_n, c2_out, c2_oe;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  bit m_f1, m_f2, m_c2, m_oe, m_p1, m_p2;

  always #10 clk = ~clk;

  ctl_line_irq dut_i (
    .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
    .c1_in(c1_in), .c2_in(c2_in), .flag_c1(flag_c1), .flag_c2(flag_c2),
    .irq_n(irq_n), .c2_out(c2_out), .c2_oe(c2_oe)
  );

  task automatic model_edge();
    bit e1, e2;
    e1 = ctrl_i[1] ? (c1_in && !m_p1) : (!c1_in && m_p1);
    e2 = !ctrl_i[5] && (ctrl_i[4] ? (c2_in && !m_p2) : (!c2_in && m_p2));
    if (rst) begin
      m_f1 = 0; m_f2 = 0; m_c2 = 1; m_oe = 0;
    end else begin
      m_f1 = e1 || (m_f1 && !ctrl_rd);
      m_f2 = e2 || (m_f2 && !ctrl_rd);
      m_oe = ctrl_i[5];
      if (!ctrl_i[5])      m_c2 = 1;
      else if (ctrl_i[4])  m_c2 = ctrl_i[3];
      else if (ctrl_i[3])  m_c2 = !data_rd;
      else if (data_rd)    m_c2 = 0;
      else if (e1)         m_c2 = 1;
    end
    m_p1 = c1_in; m_p2 = c2_in;
  endtask

  task automatic cmp(string nm, string req, logic act, bit exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit [5:0] c, bit crd, bit drd, bit p1, bit p2);
    rst = r; ctrl_i = c; ctrl_rd = crd; data_rd = drd; c1_in = p1; c2_in = p2;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vectors++;
    cmp("flag_c1", cur_req, flag_c1, m_f1);
    cmp("flag_c2", cur_req, flag_c2, m_f2);
    cmp("irq_n",   cur_req, irq_n,
        !((m_f1 && ctrl_i[0]) || (m_f2 && ctrl_i[3] && !ctrl_i[5])));
    cmp("c2_out",  cur_req, c2_out, m_c2);
    cmp("c2_oe",   cur_req, c2_oe, m_oe);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step(1, 6'h3F, 0, 0, 1, 1);
    step(0, 6'h00, 0, 0, 1, 1);

    // R2 / R4: falling C1, masked; flag latches, irq stays high
    cur_req = "R2";
    step(0, 6'b000000, 0, 0, 0, 1);
    step(0, 6'b000000, 0, 0, 0, 1);
    cur_req = "R4";
    step(0, 6'b000001, 0, 0, 0, 1);  // enabling exposes latched flag
    // R5: clear by control read
    cur_req = "R5";
    step(0, 6'b000001, 1, 0, 0, 1);
    step(0, 6'b000001, 0, 0, 0, 1);
    // R2: rising selected, falling ignored
    cur_req = "R2";
    step(0, 6'b000011, 0, 0, 1, 1);
    step(0, 6'b000011, 1, 0, 1, 1);
    step(0, 6'b000011, 0, 0, 0, 1);  // wrong polarity
    step(0, 6'b000011, 0, 0, 0, 1);

    // R3: C2 input, rising, enabled
    cur_req = "R3";
    step(0, 6'b011000, 0, 0, 0, 0);
    step(0, 6'b011000, 0, 0, 0, 1);
    step(0, 6'b011000, 0, 0, 0, 0);  // falling ignored
    step(0, 6'b001000, 1, 0, 0, 0);
    step(0, 6'b001000, 0, 0, 0, 1);  // falling selected: rise ignored
    step(0, 6'b001000, 0, 0, 0, 0);  // falling sets

    // R5: set beats clear
    cur_req = "R5";
    step(0, 6'b001011, 1, 0, 1, 0);
    step(0, 6'b001011, 0, 0, 1, 0);
    step(0, 6'b001011, 1, 0, 1, 0);
    step(0, 6'b001011, 0, 0, 1, 0);

    // R6 / R9: level output mode, C2 edges ignored
    cur_req = "R6";
    step(0, 6'b110000, 0, 0, 1, 1);
    step(0, 6'b110000, 0, 0, 1, 0);
    step(0, 6'b111000, 0, 0, 1, 1);
    step(0, 6'b111000, 0, 0, 1, 0);
    cur_req = "R3";
    step(0, 6'b111000, 0, 0, 1, 1);
    step(0, 6'b110000, 0, 0, 1, 0);

    // R7: handshake, C1 rising recovers
    cur_req = "R7";
    step(0, 6'b100010, 0, 0, 0, 0);
    step(0, 6'b100010, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 6'b100010, 0, 0, 0, 0);
    step(0, 6'b100010, 0, 0, 1, 0);
    step(0, 6'b100010, 1, 0, 1, 0);
    step(0, 6'b100010, 0, 1, 0, 0);
    step(0, 6'b100010, 0, 1, 1, 0);  // read with edge: stays low
    step(0, 6'b100010, 0, 0, 1, 0);

    // R8: strobe
    cur_req = "R8";
    step(0, 6'b101000, 0, 0, 1, 0);
    step(0, 6'b101000, 0, 1, 1, 0);
    step(0, 6'b101000, 0, 0, 1, 0);
    step(0, 6'b101000, 0, 1, 1, 0);
    step(0, 6'b101000, 0, 1, 1, 0);
    step(0, 6'b101000, 0, 0, 1, 0);

    // R9: back to input mode
    cur_req = "R9";
    step(0, 6'b000000, 1, 0, 1, 0);
    step(0, 6'b000000, 0, 1, 1, 0);
    step(0, 6'b100000, 0, 0, 1, 0);
    step(0, 6'b000000, 0, 0, 1, 0);

    // R1: reset mid-run
    cur_req = "R1";
    step(0, 6'b000011, 0, 0, 0, 0);
    step(0, 6'b000011, 0, 0, 1, 0);
    step(1, 6'b110000, 0, 0, 1, 0);
    step(0, 6'b000000, 0, 0, 1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule